// File: doc/BRIEF.md
# Radix-2² Second-Type Delay-Feedback Butterfly

This block is the second butterfly of a radix-2² single-path delay-feedback FFT stage. It accepts one complex fixed-point sample per cycle, each marked by an input valid strobe. A feedback delay line of `DEPTH` entries holds samples. The output is a stream of complex results, also marked by a valid strobe, which goes to the twiddle multiplier that follows. A modulo counter over four times `DEPTH` valid samples drives the operation, which alternates between two phases. In a fill phase, incoming samples enter the delay line and earlier differences leave it. In a butterfly phase, each incoming sample is added to the sample at the head of the delay line and subtracted from it.

In the last quarter of each counter period, the incoming sample is multiplied by minus j before it reaches the adder. This uses no multiplier: the real and imaginary parts swap places and one of them is negated. Both butterfly results are scaled down by one bit, so the stage never overflows. Idle cycles in the input stream have no effect on the results. Nothing advances while the input valid strobe is low.

Top module: `r22_bf2_sdf`

## Requirements
- R1: While reset is asserted, and after its release until the first qualifying input, `out_valid` is 0 and `out_re`/`out_im` are 0.
- R2: The phase counter counts valid inputs modulo 4·DEPTH. Cycles with `in_valid` low change nothing, so a stream with idle gaps gives the same output sequence as the same stream without gaps.
- R3: The first DEPTH valid inputs after reset produce no output. Every later valid input produces exactly one output, with `out_valid` high in the cycle after that input. `out_valid` is low in the cycle after a cycle with `in_valid` low.
- R4: The butterfly phase is the counter's second most significant bit equal to 1 (counter positions DEPTH..2·DEPTH−1 and 3·DEPTH..4·DEPTH−1). For an input x in this phase, with head sample h, the output is floor((h+x)/2) for the real and imaginary parts separately.
- R5: In the butterfly phase, floor((h−x)/2) is written into the delay line. These differences come out in their original order during the following fill phase, one per valid input, while the fill-phase inputs enter the delay line unchanged.
- R6: At counter positions 3·DEPTH..4·DEPTH−1, the input (re, im) is replaced by (im, −re) before the sum and difference. At all other positions the input is used unchanged.
- R7: The negation in R6 saturates: a real part of −2^(W−1) becomes 2^(W−1)−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_re | input | W | Input real part, two's complement |
| in_im | input | W | Input imaginary part, two's complement |
| out_valid | output | 1 | Output sample qualifier |
| out_re | output | W | Output real part, two's complement |
| out_im | output | W | Output imaginary part, two's complement |

## Verification
A phase counter that is off by one, or that moves on an idle cycle, pairs each sample with the wrong head. The output values are then wrong within DEPTH valid samples of the error. A counter period that is out of step also moves the minus-j window, so the rotated samples turn up in the wrong half of the frame. A corrupted entry in the delay line stays hidden until it is read out. That happens at most 2·DEPTH valid samples later, as a wrong sum or as a wrong drained difference. A stuck or late priming flag shows up at once in the count of `out_valid` pulses.

// File: rtl/r22_bf2_pkg.sv
package r22_bf2_pkg;
  typedef enum logic {
    PH_FILL = 1'b0,
    PH_BFLY = 1'b1
  } bf2_phase_e;
endpackage

// File: rtl/r22_bf2_delay.sv
module r22_bf2_delay #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head
);
  logic [WIDTH-1:0] stg [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic [WIDTH-1:0] src;
      if (i == 0) begin : g_first
        assign src = din;
      end else begin : g_rest
        assign src = stg[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg[i] <= '0;
        end else if (shift_en) begin
          stg[i] <= src;
        end
      end
    end
  endgenerate

  assign head = stg[DEPTH-1];
endmodule

// File: rtl/r22_bf2_rot.sv
module r22_bf2_rot #(
  parameter int W = 16
) (
  input  logic         rot_en,
  input  logic [W-1:0] a_re,
  input  logic [W-1:0] a_im,
  output logic [W-1:0] y_re,
  output logic [W-1:0] y_im
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] neg_re;

  always_comb begin
    neg_re = (a_re == MOST_NEG) ? MOST_POS : (~a_re + 1'b1);
    if (rot_en) begin
      y_re = a_im;
      y_im = neg_re;
    end else begin
      y_re = a_re;
      y_im = a_im;
    end
  end
endmodule

// File: rtl/r22_bf2_ctrl.sv
module r22_bf2_ctrl
  import r22_bf2_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output bf2_phase_e phase,
  output logic       rot_en,
  output logic       primed
);
  localparam int CW = $clog2(DEPTH) + 2;
  localparam logic [CW-1:0] LAST_FILL = CW'(DEPTH - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          primed_q, primed_d;

  always_comb begin
    cnt_d    = cnt_q;
    primed_d = primed_q;
    if (in_valid) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST_FILL) begin
        primed_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
    end
  end

  assign phase  = bf2_phase_e'(cnt_q[CW-2]);
  assign rot_en = cnt_q[CW-1] & cnt_q[CW-2];
  assign primed = primed_q;

  a_r2_hold_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q));

  a_r6_rot_in_bfly: assert property (@(posedge clk) disable iff (!rst_n)
    rot_en |-> (phase == PH_BFLY));
endmodule

// File: rtl/r22_bf2_sdf.sv
module r22_bf2_sdf
  import r22_bf2_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_re,
  input  logic [W-1:0] in_im,
  output logic         out_valid,
  output logic [W-1:0] out_re,
  output logic [W-1:0] out_im
);
  localparam int W2 = 2 * W;

  bf2_phase_e   phase;
  logic         rot_en, primed;
  logic [W-1:0] x_re, x_im, h_re, h_im;
  logic [W2-1:0] head, push;
  logic signed [W:0] sum_re, sum_im, dif_re, dif_im;
  logic [W-1:0] res_re, res_im;
  logic         ov_d, ov_q;
  logic [W-1:0] ore_d, oim_d, ore_q, oim_q;

  r22_bf2_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .phase(phase), .rot_en(rot_en), .primed(primed)
  );

  r22_bf2_rot #(.W(W)) rot_i (
    .rot_en(rot_en), .a_re(in_re), .a_im(in_im),
    .y_re(x_re), .y_im(x_im)
  );

  r22_bf2_delay #(.WIDTH(W2), .DEPTH(DEPTH)) fb_i (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
    .din(push), .head(head)
  );

  assign h_re = head[W2-1:W];
  assign h_im = head[W-1:0];

  always_comb begin
    sum_re = ({h_re[W-1], h_re} + {x_re[W-1], x_re}) >>> 1;
    sum_im = ({h_im[W-1], h_im} + {x_im[W-1], x_im}) >>> 1;
    dif_re = ({h_re[W-1], h_re} - {x_re[W-1], x_re}) >>> 1;
    dif_im = ({h_im[W-1], h_im} - {x_im[W-1], x_im}) >>> 1;
    if (phase == PH_BFLY) begin
      push   = {dif_re[W-1:0], dif_im[W-1:0]};
      res_re = sum_re[W-1:0];
      res_im = sum_im[W-1:0];
    end else begin
      push   = {x_re, x_im};
      res_re = h_re;
      res_im = h_im;
    end
  end

  always_comb begin
    ov_d  = in_valid & primed;
    ore_d = ore_q;
    oim_d = oim_q;
    if (ov_d) begin
      ore_d = res_re;
      oim_d = res_im;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q  <= 1'b0;
      ore_q <= '0;
      oim_q <= '0;
    end else begin
      ov_q  <= ov_d;
      ore_q <= ore_d;
      oim_q <= oim_d;
    end
  end

  assign out_valid = ov_q;
  assign out_re    = ore_q;
  assign out_im    = oim_q;

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  a_r3_gap_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r5_fill_drains_head: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && primed && phase == PH_FILL) |=> ({out_re, out_im} == $past(head)));
endmodule

// File: tb/r22_bf2_sdf_tb.sv
module r22_bf2_sdf_tb_top;
  localparam int W  = 16;
  localparam int D  = 4;
  localparam int N  = 96;
  localparam int NE = N - D;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_re = '0, in_im = '0;
  logic         out_valid;
  logic [W-1:0] out_re, out_im;

  int xr [N];
  int xi [N];
  int er [N];
  int ei [N];
  string etag [N];
  int n_chk = 0, n_bad = 0, oidx = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  r22_bf2_sdf #(.W(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  function automatic int sneg(int v);
    return (v == -32768) ? 32767 : -v;
  endfunction

  task automatic build();
    int seed = 7;
    int k = 0;
    for (int i = 0; i < N; i++) begin
      seed = seed * 1103515245 + 12345;
      xr[i] = int'($signed(seed[30:15]));
      seed = seed * 1103515245 + 12345;
      xi[i] = int'($signed(seed[30:15]));
    end
    xr[0] = 32767;  xi[0] = -32768;
    xr[4] = 32767;  xi[4] = 32767;
    xr[8] = -32768; xi[8] = -32768;
    xr[12] = -32768; xi[12] = 5;    // R7: saturating negate in the rotated quarter
    for (int p = 0; p < N / (2 * D); p++) begin
      for (int s = 0; s < 2; s++) begin
        for (int i = 0; i < D; i++) begin
          int ar = xr[2*D*p + i], ai = xi[2*D*p + i];
          int cr = xr[2*D*p + D + i], ci = xi[2*D*p + D + i];
          if (p % 2 == 1) begin
            int t = cr;
            cr = ci;
            ci = sneg(t);
          end
          if (k < N) begin
            er[k] = (s == 0) ? ((ar + cr) >>> 1) : ((ar - cr) >>> 1);
            ei[k] = (s == 0) ? ((ai + ci) >>> 1) : ((ai - ci) >>> 1);
            etag[k] = (p % 2 == 1) ? ((s == 0) ? "R6/R4" : "R6/R5") : ((s == 0) ? "R4" : "R5");
            k++;
          end
        end
      end
    end
  endtask

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic sample(bit prev_v, int prev_idx);
    bit exp_v = prev_v && (prev_idx >= D);
    check(out_valid == exp_v, "R3", "out_valid", int'(out_valid), int'(exp_v));
    if (out_valid && exp_v) begin
      if (oidx < NE) begin
        check(int'($signed(out_re)) == er[oidx], etag[oidx], "out_re", int'($signed(out_re)), er[oidx]);
        check(int'($signed(out_im)) == ei[oidx], etag[oidx], "out_im", int'($signed(out_im)), ei[oidx]);
      end
      oidx++;
    end
  endtask

  task automatic run_pass(bit gaps);
    bit pv = 1'b0;
    int pidx = -1;
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_re == '0 && out_im == '0, "R1", "reset state", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_re == '0 && out_im == '0, "R1", "after release", int'(out_re), 0);
    oidx = 0;
    for (int i = 0; i < N; i++) begin
      if (gaps && (i % 3 == 1)) begin
        for (int g = 0; g <= i % 4; g++) begin
          @(negedge clk);
          sample(pv, pidx);       // R2: idle cycles must not disturb the sequence
          in_valid = 1'b0;
          in_re = 16'h5A5A;
          in_im = 16'hA5A5;
          pv = 1'b0;
        end
      end
      @(negedge clk);
      sample(pv, pidx);
      in_valid = 1'b1;
      in_re = W'(xr[i]);
      in_im = W'(xi[i]);
      pv = 1'b1;
      pidx = i;
    end
    @(negedge clk);
    sample(pv, pidx);
    in_valid = 1'b0;
    @(negedge clk);
    sample(1'b0, -1);
    check(oidx == NE, gaps ? "R2" : "R3", "output count", oidx, NE);
  endtask

  initial begin
    build();
    run_pass(1'b0);
    run_pass(1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule